// File: doc/BRIEF.md
# Black-Level Servo for an Image Sensor Readout Chain

This block keeps the dark level of a sensor readout chain on target. Converter samples arrive on a valid/ready stream. A strobe marks the shielded pixels at the start of each line. While the strobe is high, the block sums the difference between an 8-bit target level and each accepted sample, and it counts those samples. When the strobe falls, the sum is averaged over the window and then damped by a programmable right shift. The result is added to a signed correction word that feeds an offset DAC ahead of the converter.

The correction holds its value between windows. Updates can be thinned out so that only one window in every N+1 moves the correction. Windows of any length from one sample upward produce an update.

The input never applies back-pressure. `s_ready` is high in every cycle outside reset, and a sample counts as accepted in any cycle where `s_valid` and `s_ready` are both high. The correction output has no handshake. It is a level for the DAC, and `corr_upd` pulses in the cycle it takes a new value.

Top module: `black_level_servo`

## Requirements
- R1: A synchronous reset (`rst` high) clears the correction to 0, empties the sample sum and count, and restarts the window counter. `corr_upd` is 0 in the first cycle after reset.
- R2: The per-sample error is target − sample, with the 8-bit target zero-extended. A sample adds to the sum only when `s_valid` and `win_i` are both high on the same clock edge. Samples taken outside the strobe have no effect on the correction.
- R3: A window closes on the first clock edge that samples `win_i` low after it was sampled high. Any update lands on that edge, and `corr_upd` is high for exactly the following cycle.
- R4: The window average is the signed sum arithmetically shifted right by floor(log2(count)), where count is the number of samples summed in the window.
- R5: The step is the average arithmetically shifted right by `cfg_shift` (0 to 7). The new correction is the old correction plus the step.
- R6: The correction is a signed 10-bit value that saturates at 511 and −512 rather than wrapping.
- R7: The correction does not change in any cycle other than an update cycle.
- R8: A window in which no sample was summed does nothing. Among the other windows, only every (`cfg_skip`+1)th one applies an update, counting from reset. With `cfg_skip` = 0, every such window updates.
- R9: Windows shorter than 20 samples, down to a single sample, update the correction under the same rules.
- R10: The sample count stops at 1023. Further samples in the same window neither add to the sum nor change the count.
- R11: `s_ready` is high in every cycle in which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, high outside reset |
| s_data | input | 12 | Unsigned converter sample |
| win_i | input | 1 | Clamp window strobe over the shielded pixels |
| cfg_target | input | 8 | Target black level in LSB |
| cfg_shift | input | 3 | Loop filter damping shift |
| cfg_skip | input | 4 | Windows skipped between updates |
| corr_o | output | 10 | Signed correction word for the offset DAC |
| corr_upd | output | 1 | One-cycle pulse when the correction is updated |

## Verification
The assertions check several properties on every cycle:
- the correction holds still outside update pulses;
- each pulse follows a strobe fall by exactly one edge and lasts one cycle;
- the state after reset is clean.

Other properties can only be shown by the bench's scenarios running against its own arithmetic model. These are:
- the averaging and damping values;
- saturation at both rails;
- thinning of updates, including how empty windows are treated;
- the 1023-sample cap;
- one-sample windows.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int SAMPLE_W = 12;
  localparam int TARGET_W = 8;
  localparam int CORR_W   = 10;
  localparam int CNT_W    = 10;
  localparam int SHIFT_W  = 3;
  localparam int SKIP_W   = 4;

  // index of the highest set bit, 0 for an all-zero word
  function automatic int msb_index(input logic [31:0] v);
    int r;
    r = 0;
    for (int b = 0; b < 32; b++) begin
      if (v[b]) r = b;
    end
    return r;
  endfunction
endpackage

// File: rtl/bls_err_accum.sv
module bls_err_accum #(
  parameter int SAMPLE_W = 12,
  parameter int TARGET_W = 8,
  parameter int CNT_W    = 10,
  parameter int ACC_W    = SAMPLE_W + 1 + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic [TARGET_W-1:0]     target_i,
  input  logic                    clear_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0]        cnt_o
);
  localparam int ERR_W = SAMPLE_W + 1;

  logic signed [ERR_W-1:0] err;
  logic                    full;

  always_comb begin
    err  = $signed({{(ERR_W-TARGET_W){1'b0}}, target_i}) - $signed({1'b0, sample_i});
    full = &cnt_o;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      acc_o <= '0;
      cnt_o <= '0;
    end else if (take_i && !full) begin
      acc_o <= acc_o + {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/bls_win_tracker.sv
module bls_win_tracker #(
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_i,
  input  logic              has_samples_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic              close_o,
  output logic              apply_o
);
  logic              win_q;
  logic [SKIP_W-1:0] skip_cnt;
  logic              counted;

  always_comb begin
    close_o = win_q && !win_i;
    counted = close_o && has_samples_i;
    apply_o = counted && (skip_cnt >= skip_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= 1'b0;
      skip_cnt <= '0;
    end else begin
      win_q <= win_i;
      if (apply_o)      skip_cnt <= '0;
      else if (counted) skip_cnt <= skip_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bls_loop_filter.sv
module bls_loop_filter #(
  parameter int ACC_W   = 23,
  parameter int CNT_W   = 10,
  parameter int SHIFT_W = 3,
  parameter int CORR_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     apply_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  output logic signed [CORR_W-1:0] corr_o,
  output logic                     upd_o
);
  import bls_pkg::*;

  localparam int LG_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;
  localparam logic signed [ACC_W:0] HI = (ACC_W+1)'((2**(CORR_W-1)) - 1);
  localparam logic signed [ACC_W:0] LO = -HI - 1;

  logic [LG_W-1:0]         lg;
  logic signed [ACC_W-1:0] avg;
  logic signed [ACC_W-1:0] step;
  logic signed [ACC_W:0]   sum;
  logic signed [CORR_W-1:0] next_corr;

  always_comb begin
    lg   = LG_W'(msb_index(32'(cnt_i)));
    avg  = acc_i >>> lg;
    step = avg >>> shift_i;
    sum  = $signed({{(ACC_W+1-CORR_W){corr_o[CORR_W-1]}}, corr_o})
         + $signed({step[ACC_W-1], step});
    if (sum > HI)      next_corr = HI[CORR_W-1:0];
    else if (sum < LO) next_corr = LO[CORR_W-1:0];
    else               next_corr = sum[CORR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= apply_i;
      if (apply_i) corr_o <= next_corr;
    end
  end
endmodule

// File: rtl/black_level_servo.sv
module black_level_servo #(
  parameter int SAMPLE_W = bls_pkg::SAMPLE_W,
  parameter int TARGET_W = bls_pkg::TARGET_W,
  parameter int CORR_W   = bls_pkg::CORR_W,
  parameter int CNT_W    = bls_pkg::CNT_W,
  parameter int SHIFT_W  = bls_pkg::SHIFT_W,
  parameter int SKIP_W   = bls_pkg::SKIP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                win_i,
  input  logic [TARGET_W-1:0] cfg_target,
  input  logic [SHIFT_W-1:0]  cfg_shift,
  input  logic [SKIP_W-1:0]   cfg_skip,
  output logic [CORR_W-1:0]   corr_o,
  output logic                corr_upd
);
  localparam int ACC_W = SAMPLE_W + 1 + CNT_W;

  logic                    take;
  logic                    close;
  logic                    apply;
  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;
  logic signed [CORR_W-1:0] corr;

  always_comb begin
    s_ready = !rst;
    take    = s_valid && s_ready && win_i;
    corr_o  = corr;
  end

  bls_err_accum #(
    .SAMPLE_W(SAMPLE_W), .TARGET_W(TARGET_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_accum (
    .clk(clk), .rst(rst), .take_i(take), .sample_i(s_data),
    .target_i(cfg_target), .clear_i(close), .acc_o(acc), .cnt_o(cnt)
  );

  bls_win_tracker #(.SKIP_W(SKIP_W)) u_track (
    .clk(clk), .rst(rst), .win_i(win_i), .has_samples_i(|cnt),
    .skip_i(cfg_skip), .close_o(close), .apply_o(apply)
  );

  bls_loop_filter #(
    .ACC_W(ACC_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .CORR_W(CORR_W)
  ) u_filter (
    .clk(clk), .rst(rst), .apply_i(apply), .acc_i(acc), .cnt_i(cnt),
    .shift_i(cfg_shift), .corr_o(corr), .upd_o(corr_upd)
  );
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int CORR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              win_i,
  input logic [CORR_W-1:0] corr_o,
  input logic              corr_upd
);
  assert_corr_held_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (corr_upd || $stable(corr_o)));

  assert_upd_after_close_R3: assert property (@(posedge clk) disable iff (rst)
    corr_upd |-> (!$past(win_i) && $past(win_i, 2)));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    corr_upd |=> !corr_upd);

  assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (corr_o == '0 && !corr_upd));
endmodule

bind black_level_servo bls_checker #(.CORR_W(CORR_W)) u_chk (
  .clk(clk), .rst(rst), .win_i(win_i), .corr_o(corr_o), .corr_upd(corr_upd)
);

// File: tb/black_level_servo_bench.sv
module black_level_servo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic        win_i = 1'b0;
  logic [7:0]  cfg_target = '0;
  logic [2:0]  cfg_shift = '0;
  logic [3:0]  cfg_skip = '0;
  logic [9:0]  corr_o;
  logic        corr_upd;

  always #(CLK_PERIOD/2) clk = ~clk;

  black_level_servo u_black_level_servo (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .win_i(win_i), .cfg_target(cfg_target), .cfg_shift(cfg_shift),
    .cfg_skip(cfg_skip), .corr_o(corr_o), .corr_upd(corr_upd)
  );

  // reference model state
  int m_corr = 0, m_acc = 0, m_cnt = 0, m_skip = 0;
  bit m_winq = 0, m_upd = 0, started = 0, done = 0;
  int vectors = 0, fails = 0;
  string req = "R1";
  logic [7:0] n_target = '0;
  logic [2:0] n_shift = '0;
  logic [3:0] n_skip = '0;
  logic       n_rst = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic model_step();
    int lg, avg, step, nc;
    started = 1;
    if (rst) begin
      m_corr = 0; m_acc = 0; m_cnt = 0; m_skip = 0; m_winq = 0; m_upd = 0;
    end else begin
      m_upd = 0;
      if (m_winq && !win_i) begin
        if (m_cnt > 0) begin
          if (m_skip >= int'(cfg_skip)) begin
            lg = 0;
            for (int b = 0; b < 16; b++) if ((m_cnt >> b) != 0) lg = b;
            avg = m_acc >>> lg;
            step = avg >>> cfg_shift;
            nc = m_corr + step;
            if (nc > 511) nc = 511;
            if (nc < -512) nc = -512;
            m_corr = nc; m_upd = 1; m_skip = 0;
          end else m_skip++;
        end
        m_acc = 0; m_cnt = 0;
      end else if (win_i && s_valid && m_cnt < CMAX) begin
        m_acc += int'(cfg_target) - int'(s_data);
        m_cnt++;
      end
      m_winq = win_i;
    end
  endtask

  task automatic check();
    if (!started) return;
    vectors++;
    if ($signed(corr_o) != m_corr) begin
      fails++;
      $display("FAIL %s corr_o got %0d expected %0d", req, $signed(corr_o), m_corr);
    end
    if (corr_upd !== m_upd) begin
      fails++;
      $display("FAIL %s corr_upd got %0b expected %0b", req, corr_upd, m_upd);
    end
    if (s_ready !== !rst) begin
      fails++;
      $display("FAIL R11 s_ready got %0b expected %0b", s_ready, !rst);
    end
  endtask

  task automatic cyc(input bit v, input logic [11:0] d, input bit w);
    @(negedge clk);
    check();
    rst = n_rst; cfg_target = n_target; cfg_shift = n_shift; cfg_skip = n_skip;
    s_valid = v; s_data = d; win_i = w;
    @(posedge clk);
    model_step();
  endtask

  function automatic logic [11:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[11:0];
  endfunction

  // mode 0: constant level, 1: random, 2: random with gaps in valid
  task automatic window(input int len, input int mode, input logic [11:0] lvl);
    for (int i = 0; i < len; i++) begin
      if (mode == 0)      cyc(1, lvl, 1);
      else if (mode == 1) cyc(1, rnd(), 1);
      else                cyc(i[0], rnd(), 1);
    end
    cyc(0, 12'd0, 0);
    cyc(1, rnd(), 0);   // sample outside the strobe: ignored
    cyc(0, 12'd0, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s", req);
      summary();
      $finish;
    end
  end

  initial begin
    req = "R1";
    cyc(0, 0, 0); cyc(1, 12'd7, 1); cyc(0, 0, 0);
    n_rst = 1'b0;
    repeat (4) cyc(0, 0, 0);

    req = "R2"; n_target = 8'd64; n_shift = 3'd0;
    window(32, 0, 12'd300);
    window(40, 2, 12'd0);
    for (int i = 0; i < 6; i++) cyc(1, rnd(), 0);

    req = "R4"; n_shift = 3'd2;
    window(3, 1, 12'd0);
    window(25, 1, 12'd0);
    window(100, 1, 12'd0);

    req = "R9";
    window(1, 0, 12'd10);
    window(2, 1, 12'd0);

    req = "R6"; n_target = 8'd255; n_shift = 3'd0;
    for (int i = 0; i < 4; i++) window(8, 0, 12'd0);
    n_target = 8'd0;
    for (int i = 0; i < 4; i++) window(8, 0, 12'd4095);

    req = "R5"; n_target = 8'd200;
    for (int k = 0; k < 8; k++) begin
      n_shift = 3'(k);
      window(16, 1, 12'd0);
    end

    req = "R8"; n_shift = 3'd1; n_skip = 4'd2;
    for (int i = 0; i < 7; i++) begin
      window(12, 1, 12'd0);
      if (i == 3) begin
        cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0);
      end
    end
    n_skip = 4'd0;
    window(5, 1, 12'd0);

    req = "R10"; n_target = 8'd100; n_shift = 3'd0;
    for (int i = 0; i < 1023; i++) cyc(1, 12'd100, 1);
    for (int i = 0; i < 8; i++) cyc(1, 12'd4095, 1);
    cyc(0, 0, 0); cyc(0, 0, 0);

    req = "R7";
    repeat (20) cyc(1, rnd(), 0);

    req = "R1"; n_rst = 1'b1;
    cyc(0, 0, 0); n_rst = 1'b0;
    repeat (3) cyc(0, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule